// File: doc/BRIEF.md
# Snapshot-and-Clear Error Counter Bank

This block accumulates error events reported by a line framer over a measurement interval. Six saturating 16-bit counters each take a single-cycle error pulse, one pulse per clock at most per counter. At the end of an interval all counters are captured together. Each live count is copied into a holding register that software reads, and the live counter restarts from zero. The held values therefore describe one complete interval, and they stay fixed while the next interval accumulates.

The end of an interval comes from one of three sources. In timer mode it is a one-cycle tick that marks each one-second boundary. In host mode it is either the rising edge of a control bit written by software, or the rising edge of an update pin from outside the clock domain. The pin passes through a two-stage synchronizer before its edge is detected. In timer mode the bit and the pin are ignored. In host mode the tick causes no capture. In both modes every tick sets a sticky flag, which stays set until software clears it.

Top module: `perf_err_counters`

## Requirements
- R1: After synchronous reset every holding register reads 0 and the one-second flag is low.
- R2: Each counter counts only its own error input, adding one for each clock in which that input is high.
- R3: A live counter that reaches 16'hFFFF stays there on further errors and does not wrap to zero.
- R4: A capture copies every live count into its holding register on the same clock edge, so that holding register i shows the pulses counted on input i since the previous capture.
- R5: A capture clears every live counter. An error pulse present in the capture cycle is counted as 1 in the new interval.
- R6: Holding registers do not change between captures, whatever errors arrive.
- R7: With the mode input low (timer mode), a cycle with the tick high causes a capture, and the manual bit and the update pin cause none.
- R8: With the mode input high (host mode), a change of the manual bit from 0 in one cycle to 1 in the next causes exactly one capture. Holding the bit high causes no further capture, and the tick causes none.
- R9: In host mode a rising update pin causes a capture on the third clock edge after it is first seen high, and causes none on the first two edges.
- R10: Every tick sets the one-second flag in either mode. The flag then stays high until a clear pulse is given, and a tick in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_pulse | input | 6 | One error pulse per counter, bit i feeds counter i |
| sec_tick | input | 1 | One-cycle one-second boundary tick |
| host_upd_en | input | 1 | 0 = timer mode, 1 = host mode |
| man_upd | input | 1 | Software update bit; a rising edge captures in host mode |
| upd_pin | input | 1 | Asynchronous update strobe; a rising edge captures in host mode |
| sec_flag_clr | input | 1 | Clears the sticky one-second flag |
| snap_o | output | 96 | Holding registers, counter i in bits [16*i+15:16*i] |
| sec_flag | output | 1 | Sticky one-second boundary flag |

## Verification
The live counters cannot be seen at the ports. A wrong live value therefore shows up only at the next capture, when it appears in a holding register one clock after the update edge. Each check forces a capture and reads the holding registers right after it. A lost clear, a missed same-cycle pulse or a counter that wraps shows up in the interval after the fault. An extra capture or a missed one changes the holding registers one edge after the trigger, or for the pin three edges after it. The bench samples the holding registers at those edges.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;

    localparam int unsigned DEF_NUM_CNT   = 6;
    localparam int unsigned DEF_CNT_W     = 16;
    localparam int unsigned DEF_SYNC_STG  = 2;

    // Which source closed the current interval
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_REG   = 2'd2,
        SRC_PIN   = 2'd3
    } upd_src_e;

    typedef struct packed {
        logic     fire;
        upd_src_e src;
    } upd_req_t;

    // Fire when a source is selected
    function automatic upd_req_t make_req(input upd_src_e s);
        upd_req_t r;
        r.src  = s;
        r.fire = (s != SRC_NONE);
        return r;
    endfunction

endpackage

// File: rtl/perf_edge_sync.sv
module perf_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    // STAGES synchronizer flops plus one flop for edge history
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/perf_upd_ctrl.sv
module perf_upd_ctrl
    import perf_cnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     host_upd_en,
    input  logic     sec_tick,
    input  logic     man_upd,
    input  logic     pin_rise,
    output upd_req_t req_o
);
    logic man_q;
    logic man_rise;

    // Bit history is tracked in every mode
    always_ff @(posedge clk) begin
        if (rst) man_q <= 1'b0;
        else     man_q <= man_upd;
    end

    assign man_rise = man_upd & ~man_q;

    always_comb begin
        upd_src_e sel;
        sel = SRC_NONE;
        if (!host_upd_en) begin
            if (sec_tick) sel = SRC_TIMER;
        end else if (man_rise) begin
            sel = SRC_REG;
        end else if (pin_rise) begin
            sel = SRC_PIN;
        end
        req_o = make_req(sel);
    end

endmodule

// File: rtl/perf_err_cnt.sv
module perf_err_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err,
    input  logic             upd,
    output logic [CNT_W-1:0] live_o,
    output logic [CNT_W-1:0] snap_o
);
    localparam logic [CNT_W-1:0] MAX_VAL = '1;
    localparam logic [CNT_W-1:0] ONE_VAL = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            snap_q <= '0;
        end else if (upd) begin
            snap_q <= live_q;
            live_q <= err ? ONE_VAL : '0;
        end else if (err && (live_q != MAX_VAL)) begin
            live_q <= live_q + ONE_VAL;
        end
    end

    assign live_o = live_q;
    assign snap_o = snap_q;

endmodule

// File: rtl/perf_err_counters.sv
module perf_err_counters
    import perf_cnt_pkg::*;
#(
    parameter int unsigned NUM_CNT  = DEF_NUM_CNT,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned SYNC_STG = DEF_SYNC_STG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CNT-1:0]       err_pulse,
    input  logic                     sec_tick,
    input  logic                     host_upd_en,
    input  logic                     man_upd,
    input  logic                     upd_pin,
    input  logic                     sec_flag_clr,
    output logic [NUM_CNT*CNT_W-1:0] snap_o,
    output logic                     sec_flag
);
    localparam int unsigned BUS_W = NUM_CNT * CNT_W;

    logic             pin_rise;
    upd_req_t         upd_req;
    logic             upd_fire;
    logic [BUS_W-1:0] live_flat;
    logic             flag_q;

    perf_edge_sync #(.STAGES(SYNC_STG)) u_pin_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (upd_pin),
        .rise_o   (pin_rise)
    );

    perf_upd_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .host_upd_en (host_upd_en),
        .sec_tick    (sec_tick),
        .man_upd     (man_upd),
        .pin_rise    (pin_rise),
        .req_o       (upd_req)
    );

    assign upd_fire = upd_req.fire;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        perf_err_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .err    (err_pulse[i]),
            .upd    (upd_fire),
            .live_o (live_flat[i*CNT_W +: CNT_W]),
            .snap_o (snap_o[i*CNT_W +: CNT_W])
        );
    end

    // Sticky boundary flag: a tick wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)               flag_q <= 1'b0;
        else if (sec_tick)     flag_q <= 1'b1;
        else if (sec_flag_clr) flag_q <= 1'b0;
    end

    assign sec_flag = flag_q;

endmodule

// File: rtl/perf_err_counters_chk.sv
module perf_err_counters_chk #(
    parameter int unsigned NUM_CNT = 6,
    parameter int unsigned CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CNT-1:0]       err_pulse,
    input logic                     sec_tick,
    input logic                     host_upd_en,
    input logic                     sec_flag_clr,
    input logic                     upd,
    input logic [NUM_CNT*CNT_W-1:0] live,
    input logic [NUM_CNT*CNT_W-1:0] snap,
    input logic                     sec_flag
);
    localparam logic [CNT_W-1:0] MAX_VAL = '1;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_a
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            (live[i*CNT_W +: CNT_W] == MAX_VAL && !upd) |=> (live[i*CNT_W +: CNT_W] == MAX_VAL))
            else $error("live counter wrapped"); // R3
        AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
            upd |=> (snap[i*CNT_W +: CNT_W] == $past(live[i*CNT_W +: CNT_W])))
            else $error("holding register not loaded"); // R4
        AST_UPD_RESTART: assert property (@(posedge clk) disable iff (rst)
            upd |=> (live[i*CNT_W +: CNT_W] == {{(CNT_W-1){1'b0}}, $past(err_pulse[i])}))
            else $error("live counter not restarted"); // R5
    end

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(snap))
        else $error("holding registers moved without capture"); // R6
    AST_TIMER_ONLY_TICK: assert property (@(posedge clk) disable iff (rst)
        !host_upd_en |-> (upd == sec_tick))
        else $error("timer mode capture mismatch"); // R7
    AST_HOST_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (host_upd_en && sec_tick && !upd) |=> $stable(snap))
        else $error("tick captured in host mode"); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> sec_flag)
        else $error("flag not set by tick"); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sec_flag && !sec_flag_clr) |=> sec_flag)
        else $error("flag dropped without clear"); // R10

endmodule

bind perf_err_counters perf_err_counters_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .err_pulse    (err_pulse),
    .sec_tick     (sec_tick),
    .host_upd_en  (host_upd_en),
    .sec_flag_clr (sec_flag_clr),
    .upd          (upd_fire),
    .live         (live_flat),
    .snap         (snap_o),
    .sec_flag     (sec_flag)
);

// File: tb/perf_err_counters_test.sv
module perf_err_counters_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   err_pulse = '0;
    logic           sec_tick = 1'b0;
    logic           host_upd_en = 1'b0;
    logic           man_upd = 1'b0;
    logic           upd_pin = 1'b0;
    logic           sec_flag_clr = 1'b0;
    logic [N*W-1:0] snap_o;
    logic           sec_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    perf_err_counters uut (
        .clk(clk), .rst(rst), .err_pulse(err_pulse), .sec_tick(sec_tick),
        .host_upd_en(host_upd_en), .man_upd(man_upd), .upd_pin(upd_pin),
        .sec_flag_clr(sec_flag_clr), .snap_o(snap_o), .sec_flag(sec_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] snap_of(input int i);
        return snap_o[i*W +: W];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive cnt[i] pulses on input i, all starting together
    task automatic drive_errs(input int cnt[N]);
        int mx = 0;
        for (int i = 0; i < N; i++) if (cnt[i] > mx) mx = cnt[i];
        for (int c = 0; c < mx; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) err_pulse[i] = (c < cnt[i]);
        end
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic tick;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < N; i++) chk("R1 snap zero", snap_of(i), 0);
        chk("R1 flag low", sec_flag, 0);
    endtask

    task automatic t_count_pattern;
        int a[N] = '{3, 0, 7, 1, 12, 5};
        int b[N] = '{1, 9, 0, 4, 2, 30};
        tick();  // start a clean interval
        drive_errs(a);
        tick();
        for (int i = 0; i < N; i++) chk("R2 R4 pattern A", snap_of(i), a[i]);
        drive_errs(b);
        tick();
        for (int i = 0; i < N; i++) chk("R2 R5 pattern B after clear", snap_of(i), b[i]);
    endtask

    task automatic t_same_cycle;
        int a[N] = '{0, 4, 0, 0, 0, 0};
        drive_errs(a);
        @(negedge clk); sec_tick = 1'b1; err_pulse[1] = 1'b1;
        @(negedge clk); sec_tick = 1'b0; err_pulse[1] = 1'b0;
        chk("R4 capture before same-cycle pulse", snap_of(1), 4);
        tick();
        chk("R5 same-cycle pulse counted as 1", snap_of(1), 1);
    endtask

    task automatic t_stable;
        int a[N] = '{6, 6, 6, 6, 6, 6};
        tick();
        drive_errs(a);
        for (int i = 0; i < N; i++) chk("R6 hold while counting", snap_of(i), 0);
    endtask

    task automatic t_timer_ignores;
        // live counts are 6 from t_stable
        @(negedge clk); man_upd = 1'b1; upd_pin = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 bit and pin ignored in timer mode", snap_of(0), 0);
        man_upd = 1'b0; upd_pin = 1'b0;
        repeat (4) @(negedge clk);
        tick();
        chk("R7 tick captures", snap_of(0), 6);
    endtask

    task automatic t_man_edge;
        int a[N] = '{3, 0, 0, 0, 0, 0};
        int b[N] = '{5, 0, 0, 0, 0, 0};
        host_upd_en = 1'b1;
        drive_errs(a);
        @(negedge clk); man_upd = 1'b1;
        @(negedge clk);
        chk("R8 rising bit captures", snap_of(0), 3);
        drive_errs(b);
        repeat (3) @(negedge clk);
        chk("R8 held bit no recapture", snap_of(0), 3);
        tick();
        chk("R8 tick ignored in host mode", snap_of(0), 3);
        chk("R10 flag set by host-mode tick", sec_flag, 1);
        @(negedge clk); man_upd = 1'b0;
        @(negedge clk); man_upd = 1'b1;
        @(negedge clk);
        chk("R8 second rising edge captures", snap_of(0), 5);
        man_upd = 1'b0;
    endtask

    task automatic t_pin;
        int a[N] = '{0, 0, 8, 0, 0, 0};
        drive_errs(a);
        @(negedge clk); upd_pin = 1'b1;
        @(negedge clk);
        chk("R9 no capture after edge 1", snap_of(2), 0);
        @(negedge clk);
        chk("R9 no capture after edge 2", snap_of(2), 0);
        @(negedge clk);
        chk("R9 capture on edge 3", snap_of(2), 8);
        repeat (3) @(negedge clk);
        upd_pin = 1'b0;
        repeat (4) @(negedge clk);
        host_upd_en = 1'b0;
    endtask

    task automatic t_sat;
        int a[N] = '{65540, 10, 0, 0, 0, 0};
        tick();
        drive_errs(a);
        tick();
        chk("R3 saturated at FFFF", snap_of(0), 16'hFFFF);
        chk("R3 neighbour unaffected", snap_of(1), 10);
    endtask

    task automatic t_flag;
        @(negedge clk); sec_flag_clr = 1'b1;
        @(negedge clk); sec_flag_clr = 1'b0;
        chk("R10 clear drops flag", sec_flag, 0);
        tick();
        repeat (3) @(negedge clk);
        chk("R10 flag sticky", sec_flag, 1);
        @(negedge clk); sec_flag_clr = 1'b1; sec_tick = 1'b1;
        @(negedge clk); sec_flag_clr = 1'b0; sec_tick = 1'b0;
        chk("R10 tick wins over clear", sec_flag, 1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_count_pattern();
        t_same_cycle();
        t_stable();
        t_timer_ignores();
        t_man_edge();
        t_pin();
        t_sat();
        t_flag();
        finish_run();
    end

endmodule